// File: doc/BRIEF.md
# SEC-DED Protected Word Memory Front End with Background Scrub

This block stands between a single requester and a single-port memory. Each memory word is 72 bits wide: 64 data bits and 8 check bits. On a requester write, the block computes the check bits and stores the full word. On a read, it recomputes the check bits from the stored data and compares them with the stored check bits. The result of that comparison, the syndrome, tells the block what to do:

- It repairs a single flipped bit.
- It refuses to repair a double flip.
- When it repairs a word, it writes the corrected word back to memory, so the stored copy is fixed as well as the returned data.

Whenever the requester asks for nothing, the block runs a scrubber. The scrubber reads the memory one address after another and repairs single upsets before a second upset can land in the same word. The requester always wins over the scrubber. If a scrub read-modify-write is already in progress, the requester waits for it to finish. The memory itself sits outside the block and returns read data one cycle after the read is issued.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A stored word is {check[7:0] in bits 71:64, data in bits 63:0}. Each data bit i has an 8-bit column value:
  - bits 0 to 55 take the 56 weight-3 byte values in ascending order;
  - bits 56 to 63 take the first eight weight-5 byte values in ascending order.
  The stored check byte is the XOR of the columns of all set data bits. Examples: bit 0 gives 8'h07, bit 55 gives 8'hE0, bit 56 gives 8'h1F, bit 63 gives 8'h57, and all-zero data gives 8'h00.
- R2: A read whose syndrome (stored check XOR recomputed check) is zero returns the stored data unchanged. Neither error flag is raised.
- R3: A single flipped bit anywhere in the 72-bit word is handled as follows:
  - a flipped data bit gives a syndrome equal to that bit's column, and the bit is inverted;
  - a flipped check bit j gives the syndrome 1<<j, and the data is left as stored.
  In both cases the original data is returned with err_corrected high.
- R4: A two-bit flip gives a non-zero syndrome of even weight. For such a syndrome:
  - err_uncorrectable is raised;
  - no bit is inverted, so the raw stored data is returned;
  - the stored word is not rewritten.
- R5: An odd-weight syndrome that matches no column (for example, seven check bits flipped, which gives syndrome 8'h7F) is reported as err_uncorrectable and is not corrected. err_corrected and err_uncorrectable are never high together.
- R6: After any correctable read, the corrected word is written back to the same address on the cycle right after the flags are reported.
- R7: The scrubber behaves as follows:
  - on every cycle the block is idle and req_valid is low, it starts a read of the next scrub address;
  - the scrub address goes from DEPTH-1 back to 0;
  - it repairs single errors in memory through the same write-back path;
  - its error flags pulse with rd_valid low.
- R8: While req_valid is high, no new scrub starts, and req_ready is low for at most 2 consecutive cycles.
- R9: Acceptance and output timing are as follows:
  - a request is taken on a rising edge where req_valid and req_ready are both high;
  - a write updates memory on that edge;
  - for a read, rd_valid, rd_data and the flags appear for exactly one cycle after the second edge.
- R10: During reset, req_ready is high and rd_valid, err_corrected and err_uncorrectable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester access pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Requester word address |
| req_wdata | input | DATA_W (64) | Write data |
| req_ready | output | 1 | Request is taken on this cycle's edge |
| rd_data | output | DATA_W (64) | Read data, corrected when possible |
| rd_valid | output | 1 | One-cycle pulse marking rd_data for a requester read |
| err_corrected | output | 1 | One-cycle pulse: a single error was repaired |
| err_uncorrectable | output | 1 | One-cycle pulse: the error cannot be repaired |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W (4) | Memory address |
| mem_wdata | output | WORD_W (72) | Word to store |
| mem_rdata | input | WORD_W (72) | Stored word, valid one cycle after a read |

## Verification
The assertions rely on three assumptions about the block's inputs:
- mem_rdata holds the addressed word one cycle after a read enable;
- req_addr stays below DEPTH;
- the requester keeps req_valid high until the request is taken, and nothing else writes memory at the same time.

The bench satisfies all three. It models the memory as a registered array. It keeps each request stable until the edge where req_ready is seen high. It flips stored bits through an injection port in that model, on an edge where the block is not writing the same address.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_FIX  = 2'd2
  } ctl_state_e;

  // Column value of data bit idx: odd weights from 3 upward, ascending within each weight.
  function automatic int unsigned hsiao_data_col(int unsigned idx, int unsigned cw);
    int unsigned seen;
    int unsigned found;
    seen  = 0;
    found = 0;
    for (int unsigned w = 3; w <= cw; w += 2) begin
      for (int unsigned v = 1; v < (32'd1 << cw); v++) begin
        if ($countones(v) == w) begin
          if (seen == idx) found = v;
          seen++;
        end
      end
    end
    return found;
  endfunction

  // Smallest check width whose odd-weight columns cover the data and check bits.
  function automatic int unsigned chk_bits_for(int unsigned dw);
    int unsigned c;
    c = 2;
    while ((32'd1 << (c - 1)) < (dw + c)) c++;
    return c;
  endfunction

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);

  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    logic [DATA_W-1:0] row;
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
      localparam int unsigned COLV = hsiao_data_col(i, CHK_W);
      assign row[i] = 1'((COLV >> j) & 32'd1);
    end
    assign check[j] = ^(data & row);
  end

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic [DATA_W+CHK_W-1:0] word_in,
  output logic [DATA_W-1:0]       fixed_data,
  output logic [DATA_W+CHK_W-1:0] fixed_word,
  output logic                    single_ok,
  output logic                    uncorr
);

  logic [DATA_W-1:0] raw_data;
  logic [CHK_W-1:0]  raw_chk;
  logic [CHK_W-1:0]  calc_chk;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              syn_odd;
  logic              chk_err;

  assign raw_data = word_in[DATA_W-1:0];
  assign raw_chk  = word_in[DATA_W+CHK_W-1:DATA_W];

  ecc_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
    .data  (raw_data),
    .check (calc_chk)
  );

  assign syn = raw_chk ^ calc_chk;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [CHK_W-1:0] COLB = CHK_W'(hsiao_data_col(i, CHK_W));
    assign flip[i] = (syn == COLB);
  end

  assign syn_odd    = ^syn;
  assign chk_err    = $onehot(syn);
  assign single_ok  = (|flip) | chk_err;
  assign uncorr     = (|syn) & ~single_ok;
  assign fixed_data = raw_data ^ flip;
  assign fixed_word = {raw_chk ^ (chk_err ? syn : '0), fixed_data};

  always_comb begin
    AST_FLIP_ONEHOT: assert ($onehot0(flip)); // R3
    if ((syn != '0) && !syn_odd) begin
      AST_EVEN_NO_FIX: assert (!single_ok && (flip == '0)); // R4
    end
  end

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (adv) addr_d = (addr == ADDR_W'(DEPTH - 1)) ? '0 : addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (adv) addr <= addr_d;
  end

  AST_SCRUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && addr == ADDR_W'(DEPTH - 1)) |=> (addr == '0)); // R7

endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
  import ecc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int CHK_W  = chk_bits_for(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_corrected,
  output logic              err_uncorrectable,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  ctl_state_e        st_q, st_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic              scrub_q, scrub_d;
  logic [WORD_W-1:0] fix_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_d, corr_d, unc_d;
  logic              load_op, load_out;
  logic              scrub_go;
  logic [ADDR_W-1:0] scrub_addr;
  logic [CHK_W-1:0]  wr_chk;
  logic [DATA_W-1:0] dec_data;
  logic [WORD_W-1:0] dec_word;
  logic              dec_single, dec_uncorr;

  ecc_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wr_enc (
    .data  (req_wdata),
    .check (wr_chk)
  );

  ecc_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .word_in    (mem_rdata),
    .fixed_data (dec_data),
    .fixed_word (dec_word),
    .single_ok  (dec_single),
    .uncorr     (dec_uncorr)
  );

  scrub_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (scrub_go),
    .addr  (scrub_addr)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign load_out  = (st_q == ST_READ);

  always_comb begin
    st_d       = st_q;
    op_addr_d  = op_addr_q;
    scrub_d    = scrub_q;
    load_op    = 1'b0;
    scrub_go   = 1'b0;
    rd_valid_d = 1'b0;
    corr_d     = 1'b0;
    unc_d      = 1'b0;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = op_addr_q;
    mem_wdata  = fix_q;
    unique case (st_q)
      ST_IDLE: begin
        mem_en = 1'b1;
        if (req_valid) begin
          mem_addr = req_addr;
          if (req_write) begin
            mem_we    = 1'b1;
            mem_wdata = {wr_chk, req_wdata};
          end else begin
            load_op   = 1'b1;
            op_addr_d = req_addr;
            scrub_d   = 1'b0;
            st_d      = ST_READ;
          end
        end else begin
          mem_addr  = scrub_addr;
          scrub_go  = 1'b1;
          load_op   = 1'b1;
          op_addr_d = scrub_addr;
          scrub_d   = 1'b1;
          st_d      = ST_READ;
        end
      end
      ST_READ: begin
        rd_valid_d = ~scrub_q;
        corr_d     = dec_single;
        unc_d      = dec_uncorr;
        st_d       = dec_single ? ST_FIX : ST_IDLE;
      end
      ST_FIX: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q              <= ST_IDLE;
      op_addr_q         <= '0;
      scrub_q           <= 1'b0;
      fix_q             <= '0;
      rd_data_q         <= '0;
      rd_valid          <= 1'b0;
      err_corrected     <= 1'b0;
      err_uncorrectable <= 1'b0;
    end else begin
      st_q              <= st_d;
      rd_valid          <= rd_valid_d;
      err_corrected     <= corr_d;
      err_uncorrectable <= unc_d;
      if (load_op) begin
        op_addr_q <= op_addr_d;
        scrub_q   <= scrub_d;
      end
      if (load_out) begin
        fix_q <= dec_word;
        if (!scrub_q) rd_data_q <= dec_data;
      end
    end
  end

  assign rd_data = rd_data_q;

  // Counts consecutive cycles a pending request is refused.
  logic [1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hold_q <= '0;
    else if (req_valid && !req_ready) hold_q <= (hold_q == 2'd3) ? 2'd3 : hold_q + 2'd1;
    else                            hold_q <= '0;
  end

  AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q != 2'd3); // R8
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corrected && err_uncorrectable)); // R5
  AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    err_corrected |-> (mem_en && mem_we)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R9

endmodule

// File: tb/sim_ecc_scrub_mem.sv
module sim_ecc_scrub_mem;

  localparam int DW  = 64;
  localparam int DEP = 16;
  localparam int AW  = 4;
  localparam int WW  = 72;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic [DW-1:0] rd_data;
  logic          rd_valid, err_corrected, err_uncorrectable;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata;

  logic          inj_en;
  logic [AW-1:0] inj_addr;
  logic [WW-1:0] inj_mask;
  logic [WW-1:0] mem [DEP];

  int n_chk  = 0;
  int n_fail = 0;
  int scrub_fix_cnt = 0;

  ecc_scrub_mem #(.DATA_W(DW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .err_corrected(err_corrected), .err_uncorrectable(err_uncorrectable),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model with registered read and a bit-flip injection port.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEP; i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (mem_en) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else mem_rdata <= mem[mem_addr] ^ ((inj_en && inj_addr == mem_addr) ? inj_mask : '0);
      end
    end
  end

  always @(negedge clk)
    if (rst_n && err_corrected && !rd_valid) scrub_fix_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input [AW-1:0] a, input [DW-1:0] d, input [WW-1:0] mask);
    int w;
    bit rdy;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    inj_en = (mask != '0); inj_addr = a; inj_mask = mask;
    w = 0;
    rdy = req_ready;
    while (!rdy && w < 10) begin
      @(negedge clk);
      inj_en = 1'b0;
      w++;
      rdy = req_ready;
    end
    @(negedge clk);
    inj_en = 1'b0;
    req_valid = 1'b0;
    chk(w <= 2, "R8 hold cycles", WW'(w), WW'(2));
  endtask

  task automatic do_write(input [AW-1:0] a, input [DW-1:0] d);
    issue(1'b1, a, d, '0);
  endtask

  // Returns at the negedge where the read result is presented.
  task automatic do_read(input [AW-1:0] a, input [WW-1:0] mask, input [DW-1:0] exp_d,
                         input bit exp_c, input bit exp_u, input string tag);
    issue(1'b0, a, '0, mask);
    chk(rd_valid == 1'b0, {tag, " R9 not yet valid"}, WW'(rd_valid), '0);
    @(negedge clk);
    chk(rd_valid == 1'b1, {tag, " R9 rd_valid"}, WW'(rd_valid), WW'(1));
    chk(rd_data == exp_d, {tag, " data"}, WW'(rd_data), WW'(exp_d));
    chk(err_corrected == exp_c, {tag, " err_corrected"}, WW'(err_corrected), WW'(exp_c));
    chk(err_uncorrectable == exp_u, {tag, " err_uncorrectable"}, WW'(err_uncorrectable), WW'(exp_u));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 req_ready in reset", WW'(req_ready), WW'(1));
    chk({rd_valid, err_corrected, err_uncorrectable} == 3'b000, "R10 outputs in reset",
        WW'({rd_valid, err_corrected, err_uncorrectable}), '0);
  endtask

  task automatic t_encode;
    logic [DW-1:0] d [6];
    logic [7:0]    c [6];
    d[0] = 64'h1;          c[0] = 8'h07;
    d[1] = 64'h1 << 55;    c[1] = 8'hE0;
    d[2] = 64'h1 << 56;    c[2] = 8'h1F;
    d[3] = 64'h1 << 63;    c[3] = 8'h57;
    d[4] = (64'h1 << 56) | 64'h1; c[4] = 8'h18;
    d[5] = '0;             c[5] = 8'h00;
    for (int k = 0; k < 6; k++) begin
      do_write(AW'(k + 1), d[k]);
      chk(mem[k + 1] == {c[k], d[k]}, "R1 stored codeword", mem[k + 1], {c[k], d[k]});
    end
  endtask

  task automatic t_clean;
    logic [DW-1:0] pat [3];
    pat[0] = 64'hDEAD_BEEF_0123_4567;
    pat[1] = '1;
    pat[2] = 64'hAAAA_5555_AAAA_5555;
    for (int k = 0; k < 3; k++) begin
      do_write(AW'(8 + k), pat[k]);
      do_read(AW'(8 + k), '0, pat[k], 1'b0, 1'b0, "R2 clean read");
      @(negedge clk);
      chk(rd_valid == 1'b0, "R9 single-cycle pulse", WW'(rd_valid), '0);
    end
  endtask

  task automatic t_single;
    int bits [5];
    logic [WW-1:0] orig;
    logic [DW-1:0] d;
    bits[0] = 0; bits[1] = 37; bits[2] = 63; bits[3] = 64; bits[4] = 71;
    d = 64'h0F1E_2D3C_4B5A_6978;
    do_write(AW'(12), d);
    for (int k = 0; k < 5; k++) begin
      orig = mem[12];
      do_read(AW'(12), WW'(1) << bits[k], d, 1'b1, 1'b0, "R3 single flip");
      @(negedge clk);
      chk(mem[12] == orig, "R6 write-back restores word", mem[12], orig);
    end
  endtask

  task automatic t_double;
    logic [WW-1:0] masks [2];
    logic [WW-1:0] orig;
    logic [DW-1:0] d;
    masks[0] = (WW'(1) << 3) | (WW'(1) << 40);
    masks[1] = (WW'(1) << 64) | (WW'(1) << 10);
    d = 64'h1357_9BDF_2468_ACE0;
    for (int k = 0; k < 2; k++) begin
      do_write(AW'(13), d);
      orig = mem[13];
      do_read(AW'(13), masks[k], d ^ masks[k][DW-1:0], 1'b0, 1'b1, "R4 double flip");
      @(negedge clk);
      chk(mem[13] == (orig ^ masks[k]), "R4 no write-back", mem[13], orig ^ masks[k]);
    end
    do_write(AW'(13), d);
  endtask

  task automatic t_nomatch;
    logic [WW-1:0] mask;
    logic [WW-1:0] orig;
    logic [DW-1:0] d;
    mask = WW'(8'h7F) << 64;
    d = 64'h0000_FFFF_0000_FFFF;
    do_write(AW'(14), d);
    orig = mem[14];
    do_read(AW'(14), mask, d, 1'b0, 1'b1, "R5 odd syndrome without column");
    @(negedge clk);
    chk(mem[14] == (orig ^ mask), "R5 word left as stored", mem[14], orig ^ mask);
    do_write(AW'(14), d);
  endtask

  task automatic t_scrub;
    logic [WW-1:0] a_last, a_first;
    int c0;
    do_write(AW'(DEP - 1), 64'hFEED_FACE_CAFE_F00D);
    do_write(AW'(0), 64'h0123_4567_89AB_CDEF);
    a_last  = mem[DEP - 1];
    a_first = mem[0];
    c0 = scrub_fix_cnt;
    @(negedge clk);
    inj_en = 1'b1; inj_addr = AW'(DEP - 1); inj_mask = WW'(1) << 20;
    @(negedge clk);
    inj_en = 1'b1; inj_addr = AW'(0); inj_mask = WW'(1) << 66;
    @(negedge clk);
    inj_en = 1'b0;
    repeat (6 * DEP) @(negedge clk);
    chk(mem[DEP - 1] == a_last, "R7 scrub repairs last address", mem[DEP - 1], a_last);
    chk(mem[0] == a_first, "R7 scrub repairs address 0 after wrap", mem[0], a_first);
    chk((scrub_fix_cnt - c0) >= 2, "R7 scrub flag pulses", WW'(scrub_fix_cnt - c0), WW'(2));
  endtask

  task automatic t_priority;
    for (int k = 0; k < 4; k++) begin
      repeat (k) @(negedge clk);
      do_read(AW'(8), '0, 64'hDEAD_BEEF_0123_4567, 1'b0, 1'b0, "R8 request during scrub");
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_encode();
    t_clean();
    t_single();
    t_double();
    t_nomatch();
    t_scrub();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule